// File: doc/BRIEF.md
# Bit-clock and frame-sync generator

This block derives a serial bit clock from a source clock and places a periodic frame-sync pulse on that bit clock. It is meant for an audio or synchronous serial port whose shifters run on the system clock. The shifters advance on a one-cycle strobe that marks each rising edge of the bit clock, so they never have to clock on the divided signal itself. The source can be the system clock itself or an external clock pin. The external pin is synchronized, and each rising edge on it counts as one source tick.

A single control word sets the divide ratio, the frame length, the sync pulse width, the sync mode and the clock source. The bit clock and the frame sync have separate enables, so a port can start its bit clock first and release frame sync later. The polarity of the sync pulse is chosen by a plain input. The block has no data path, so none of its pins carries a handshake. The control word should be changed only while the generator enable is low.

Top module: `bitclk_frame_gen`

## Requirements
- R1: While gen_en is low, bclk and bclk_tick are low, fsync sits at its inactive level (equal to fs_pol), and the divider and frame position restart.
- R2: ctrl_word[7:0] holds D, and the divide ratio is N = D + 1 source ticks per bit-clock period (1 to 256), with one bclk_tick per period.
- R3: Within each bit period, bclk is high for the first ceil(N/2) source ticks and low for the remaining floor(N/2). With N = 1, bclk stays high.
- R4: bclk_tick is high for exactly one system-clock cycle, the cycle in which bclk goes high at the start of a bit period.
- R5: ctrl_word[27:16] holds P, and a frame lasts P + 1 bit periods.
- R6: ctrl_word[15:8] holds W, and frame sync is active during the first W + 1 bit periods of each frame. When W >= P, frame sync stays active for the whole frame.
- R7: With fs_pol = 0 the active level of fsync is high. With fs_pol = 1 it is low.
- R8: With gen_en high and fs_en low, the bit clock runs normally and fsync stays inactive.
- R9: When fs_en is raised in the middle of a frame, fsync stays inactive until the start of the next frame.
- R10: When ctrl_word[28] (periodic sync mode) is clear, fsync stays inactive.
- R11: ctrl_word[29] = 1 makes every system-clock cycle a source tick. ctrl_word[29] = 0 makes each rising edge of the synchronized ext_clk a source tick.
- R12: The first source tick after gen_en rises starts bit period 0 and frame position 0. With the internal source, bclk, bclk_tick and the frame sync take their period-start values in the cycle right after the first clock edge at which gen_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 30 | Divider [7:0], pulse width [15:8], frame period [27:16], periodic mode [28], internal source [29] |
| ext_clk | input | 1 | External source clock, sampled by a synchronizer |
| gen_en | input | 1 | Bit-clock generator enable |
| fs_en | input | 1 | Frame-sync enable |
| fs_pol | input | 1 | Frame-sync polarity, 1 = active low |
| bclk | output | 1 | Divided bit clock |
| bclk_tick | output | 1 | One-cycle strobe at each bit-clock rising edge |
| fsync | output | 1 | Frame-sync output |

## Verification
Two events can fall on the same source tick: a frame start and a bit-period start. The bench sweeps small divider, period and width values, and in every cycle it checks that fsync turns active exactly where the strobe opens bit 0 of a frame. A second coincidence is the arrival of fs_en and a frame boundary. To provoke it, the bench raises fs_en in mid-frame and expects fsync to stay inactive until the next strobe that begins a frame. The bench also raises gen_en and fs_en together and expects the first frame to carry a full pulse.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  localparam int DIV_W  = 8;
  localparam int WID_W  = 8;
  localparam int PER_W  = 12;
  localparam int CTRL_W = DIV_W + WID_W + PER_W + 2;

  typedef struct packed {
    logic             src_int;
    logic             periodic;
    logic [PER_W-1:0] period;
    logic [WID_W-1:0] width;
    logic [DIV_W-1:0] div;
  } bfg_ctrl_t;
endpackage

// File: rtl/bfg_src_sel.sv
module bfg_src_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic src_int,
  output logic tick
);
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
  end

  // a source tick is every cycle, or one per synchronized rising edge
  assign tick = src_int | (sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES]);
endmodule

// File: rtl/bfg_bitclk.sv
module bfg_bitclk
  import bfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             bclk,
  output logic             bclk_tick,
  output logic             bit_start,
  output logic             first
);
  logic [DIV_W-1:0] cnt_q;
  logic             active_q;
  logic             strobe_q;
  logic [DIV_W:0]   hi_len;
  logic             wrap;

  assign wrap      = (cnt_q >= div);
  assign first     = !active_q;
  assign bit_start = gen_en && tick && (!active_q || wrap);
  assign hi_len    = ({1'b0, div} + (DIV_W+1)'(2)) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      strobe_q <= 1'b0;
    end else if (!gen_en) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= bit_start;
      if (tick) begin
        if (!active_q) begin
          active_q <= 1'b1;
          cnt_q    <= '0;
        end else if (wrap) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + DIV_W'(1);
        end
      end
    end
  end

  assign bclk      = active_q && ({1'b0, cnt_q} < hi_len);
  assign bclk_tick = strobe_q;

  a_r4_tick_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tick |-> bclk);
  a_r4_rise_has_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> bclk_tick);
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!bclk && !bclk_tick));
endmodule

// File: rtl/bfg_frame.sv
module bfg_frame
  import bfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             fs_en,
  input  logic             periodic,
  input  logic             bit_start,
  input  logic             first,
  input  logic [PER_W-1:0] period,
  input  logic [WID_W-1:0] width,
  input  logic             fs_pol,
  output logic             fsync
);
  localparam int PAD_W = PER_W - WID_W;

  logic [PER_W-1:0] pos_q;
  logic             armed_q;
  logic             fs_act;
  logic             allow;

  assign allow = fs_en && periodic;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      armed_q <= 1'b0;
    end else if (!gen_en) begin
      pos_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (!allow) armed_q <= 1'b0;
      if (bit_start) begin
        if (first || pos_q >= period) begin
          pos_q <= '0;
          if (allow) armed_q <= 1'b1;
        end else begin
          pos_q <= pos_q + PER_W'(1);
        end
      end
    end
  end

  assign fs_act = armed_q && ({{PAD_W{1'b0}}, width} >= pos_q);
  assign fsync  = fs_act ^ fs_pol;

  a_r9_rise_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fs_act) && $stable(width)) |-> (pos_q == '0));
  a_r8_gated_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_en |=> !fs_act);
  a_r1_idle_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !fs_act);
endmodule

// File: rtl/bitclk_frame_gen.sv
module bitclk_frame_gen
  import bfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              ext_clk,
  input  logic              gen_en,
  input  logic              fs_en,
  input  logic              fs_pol,
  output logic              bclk,
  output logic              bclk_tick,
  output logic              fsync
);
  bfg_ctrl_t ctl;
  logic      tick;
  logic      bit_start;
  logic      first;

  assign ctl = bfg_ctrl_t'(ctrl_word);

  bfg_src_sel #(.SYNC_STAGES(SYNC_STAGES)) src_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_clk (ext_clk),
    .src_int (ctl.src_int),
    .tick    (tick)
  );

  bfg_bitclk div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .tick      (tick),
    .div       (ctl.div),
    .bclk      (bclk),
    .bclk_tick (bclk_tick),
    .bit_start (bit_start),
    .first     (first)
  );

  bfg_frame frm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .fs_en     (fs_en),
    .periodic  (ctl.periodic),
    .bit_start (bit_start),
    .first     (first),
    .period    (ctl.period),
    .width     (ctl.width),
    .fs_pol    (fs_pol),
    .fsync     (fsync)
  );
endmodule

// File: tb/bitclk_frame_gen_tb_top.sv
`timescale 1ns/1ps
module bitclk_frame_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] ctrl_word = '0;
  logic        ext_clk = 1'b0;
  logic        gen_en = 1'b0;
  logic        fs_en = 1'b0;
  logic        fs_pol = 1'b0;
  logic        bclk, bclk_tick, fsync;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bitclk_frame_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ext_clk(ext_clk),
    .gen_en(gen_en), .fs_en(fs_en), .fs_pol(fs_pol),
    .bclk(bclk), .bclk_tick(bclk_tick), .fsync(fsync)
  );

  function automatic logic [29:0] mk(int d, int w, int p, bit per_mode, bit src);
    logic [29:0] v;
    v = {src, per_mode, 12'(p), 8'(w), 8'(d)};
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cfg(int d, int p, int w, bit pol);
    int n, ph, b, pos, len;
    @(negedge clk);
    gen_en = 0; fs_en = 0; fs_pol = pol;
    ctrl_word = mk(d, w, p, 1, 1);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(bclk == 0 && bclk_tick == 0, "R1 idle clock", {bclk, bclk_tick}, 0);
      chk(fsync == pol, "R1 idle sync", fsync, pol);
    end
    gen_en = 1; fs_en = 1;
    n = d + 1;
    len = 2 * (p + 1) * n;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      ph = k % n; b = k / n; pos = b % (p + 1);
      chk(bclk == (ph < (n + 1) / 2), "R3 R12 bclk", bclk, int'(ph < (n + 1) / 2));
      chk(bclk_tick == (ph == 0), "R2 R4 strobe", bclk_tick, int'(ph == 0));
      chk(fsync == (pol ^ (pos <= w)), "R5 R6 R7 fsync", fsync, int'(pol ^ (pos <= w)));
    end
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk(bclk == 0 && bclk_tick == 0 && fsync == 0, "R1 reset", {bclk, bclk_tick, fsync}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(bclk == 0 && bclk_tick == 0 && fsync == 0, "R1 after reset", {bclk, bclk_tick, fsync}, 0);

    // sweep over divider, frame period and width (including width >= period)
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 5; p++)
        for (int w = 0; w <= p + 1; w++)
          run_cfg(d, p, w, bit'((d + p + w) % 2));

    // R8: bit clock running, sync held off; then R9: fs_en raised mid-frame
    @(negedge clk);
    gen_en = 0; fs_en = 0; fs_pol = 0;
    ctrl_word = mk(1, 0, 3, 1, 1);
    @(negedge clk);
    gen_en = 1;
    cnt = 0;
    for (int k = 0; k < 19; k++) begin
      @(negedge clk);
      if (bclk_tick) cnt++;
      chk(fsync == 0, "R8 sync held off", fsync, 0);
    end
    chk(cnt == 10, "R8 strobes while sync off", cnt, 10);
    fs_en = 1;
    for (int k = 19; k < 34; k++) begin
      @(negedge clk);
      chk(fsync == ((k >= 24) && ((k / 2) % 4 == 0)), "R9 first pulse at frame start",
          fsync, int'((k >= 24) && ((k / 2) % 4 == 0)));
    end

    // R10: periodic mode clear
    @(negedge clk);
    gen_en = 0;
    ctrl_word = mk(0, 1, 3, 0, 1);
    @(negedge clk);
    gen_en = 1; fs_en = 1;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (bclk_tick) cnt++;
      chk(fsync == 0, "R10 sync inactive", fsync, 0);
    end
    chk(cnt == 20, "R10 clock still runs", cnt, 20);

    // R11: external source, idle pin gives no ticks
    @(negedge clk);
    gen_en = 0;
    ctrl_word = mk(0, 0, 3, 1, 0);
    ext_clk = 0;
    @(negedge clk);
    gen_en = 1;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (bclk_tick) cnt++;
    end
    chk(cnt == 0, "R11 idle external pin", cnt, 0);
    for (int div = 0; div < 2; div++) begin
      @(negedge clk);
      gen_en = 0;
      ctrl_word = mk(div, 0, 3, 1, 0);
      @(negedge clk);
      gen_en = 1;
      cnt = 0;
      for (int k = 0; k < 96; k++) begin
        @(negedge clk);
        if (k >= 16 && bclk_tick) cnt++;
        ext_clk = ((k / 4) % 2) == 1;
      end
      chk(cnt == 10 / (div + 1), "R11 external edge count", cnt, 10 / (div + 1));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule